// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block is the interrupt front end of a small 8-bit processor core. It keeps a per-source enable mask and a per-source pending-flag register for five interrupt sources. It also runs a four-state master-enable machine. Peripherals raise interrupts with one-cycle request pulses, and each pulse latches a pending flag. The core tells the block about each instruction boundary with a step strobe. At a step the block decides whether execution must be redirected to a fixed service address.

The core reports the enable-interrupt, disable-interrupt and return-from-interrupt instructions through three strobes. Enabling takes effect only after two further steps, while a return-from-interrupt enables at once. A dispatch has four effects:

- It drives the winning source's service address for that step.
- It reports a cost of five machine cycles.
- It clears the winning pending flag and turns the master enable off.
- It asks the bus side to push the current program counter. That push request stays raised until the push is acknowledged.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: During and right after reset, the enable mask and the pending flags read zero, `me_state_o` is 0 (off), and `push_req_o` and `disp_valid_o` are low.
- R2: Register select 0 is the enable mask and select 1 is the pending flags. A write keeps only bits 4..0, and a read returns zeros in bits 7..5. Sources are bit 0 vertical blank, bit 1 display status, bit 2 timer, bit 3 serial, bit 4 keypad.
- R3: A pulse on `req_i[k]` sets pending flag k on the next clock edge.
- R4: The `me_state_o` encoding is 0 off, 1 armed, 2 primed, 3 live. An enable strobe moves the state to armed. A step moves armed to primed and primed to live, and no dispatch happens on either of those steps.
- R5: A disable strobe makes the state off on the next edge, and this cancels an armed or primed enable.
- R6: A return strobe makes the state live on the next edge, without passing through armed or primed.
- R7: A dispatch (`disp_valid_o` high) happens only on a step where the state is already live and (mask AND flags AND 0x1F) is nonzero.
- R8: The lowest set bit of the serviceable set wins. The service address is 0x40 + 8 × bit index, giving 0x40, 0x48, 0x50, 0x58 and 0x60.
- R9: A dispatch clears only the winning pending flag, sets the state to off, and shows 5 on `cost_o`.
- R10: On the edge that ends a dispatch step, `push_req_o` rises and `push_addr_o` holds the `pc_i` value from that step. Both stay until `push_done_i` is sampled high.
- R11: If a request pulse and a dispatch clear hit the same flag in the same cycle, the flag ends set.
- R12: When strobes arrive together, disable beats return, and return beats enable. A strobe overrides the state change that a step in the same cycle would cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | One-cycle request pulses, one per source |
| ei_i | input | 1 | Enable-interrupt strobe |
| di_i | input | 1 | Disable-interrupt strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| step_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 16 | Current program counter |
| reg_wr_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | Register select: 0 mask, 1 flags |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on select |
| disp_valid_o | output | 1 | Dispatch taken on this step |
| vector_o | output | 16 | Service address of the winning source |
| cost_o | output | 4 | Machine cycles charged for the dispatch |
| me_state_o | output | 2 | Master-enable state |
| push_req_o | output | 1 | Request to push the return address |
| push_addr_o | output | 16 | Return address to push |
| push_done_i | input | 1 | Push acknowledge |

## Verification
The encoder is tried with single pending bits, and with mixed sets such as 0x1A and 0x1F where several lower-priority bits sit above the winner. The mixed sets show that the lowest bit wins and that only that one flag clears. Steps are also issued with the state off, armed and primed while flags are pending, and with a mask that hides every pending flag. These separate "live and serviceable" from the weaker conditions. Strobe collisions, and a request pulse landing on the bit being cleared, exercise the ordering rules.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    localparam int unsigned SRC_COUNT       = 5;
    localparam int unsigned PC_W            = 16;
    localparam int unsigned REG_W           = 8;
    localparam int unsigned CYC_W           = 4;
    localparam int unsigned DISPATCH_CYCLES = 5;
    localparam int unsigned VEC_BASE_ADDR   = 'h40;
    localparam int unsigned VEC_STRIDE      = 8;

    typedef enum logic [1:0] {
        ME_OFF    = 2'd0,
        ME_ARMED  = 2'd1,
        ME_PRIMED = 2'd2,
        ME_LIVE   = 2'd3
    } me_state_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N     = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     onehot_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    // Isolate the lowest set bit
    assign onehot_o = cand_i & (~cand_i + N'(1));
    assign any_o    = |cand_i;

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int unsigned N      = 5,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BASE   = 'h40,
    parameter int unsigned STRIDE = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] vec_o
);

    logic [ADDR_W-1:0] lut [N];

    for (genvar g = 0; g < N; g++) begin : g_vec
        assign lut[g] = ADDR_W'(BASE + g * STRIDE);
    end

    always_comb begin
        vec_o = lut[0];
        for (int i = 0; i < N; i++) begin
            if (idx_i == IDX_W'(i)) begin
                vec_o = lut[i];
            end
        end
    end

endmodule

// File: rtl/irq_me_fsm.sv
module irq_me_fsm
    import irq_disp_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      step_i,
    input  logic      ei_i,
    input  logic      di_i,
    input  logic      reti_i,
    input  logic      dispatch_i,
    output me_state_e state_o
);

    me_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            unique case (st_q)
                ME_ARMED:  st_d = ME_PRIMED;
                ME_PRIMED: st_d = ME_LIVE;
                ME_LIVE:   st_d = dispatch_i ? ME_OFF : ME_LIVE;
                default:   st_d = st_q;
            endcase
        end
        // Strobes take effect after the step transition
        if (di_i) begin
            st_d = ME_OFF;
        end else if (reti_i) begin
            st_d = ME_LIVE;
        end else if (ei_i) begin
            st_d = ME_ARMED;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= ME_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
    import irq_disp_pkg::*;
#(
    parameter int unsigned NUM_SRC  = SRC_COUNT,
    parameter int unsigned ADDR_W   = PC_W,
    parameter int unsigned DATA_W   = REG_W,
    parameter int unsigned COST_W   = CYC_W,
    parameter int unsigned VEC_BASE = VEC_BASE_ADDR,
    parameter int unsigned VEC_STEP = VEC_STRIDE
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              reti_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              disp_valid_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [COST_W-1:0] cost_o,
    output logic [1:0]        me_state_o,
    output logic              push_req_o,
    output logic [ADDR_W-1:0] push_addr_o,
    input  logic              push_done_i
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] flg;
        logic               push_pend;
        logic [ADDR_W-1:0]  push_pc;
    } regs_t;

    regs_t              r_d, r_q;
    me_state_e          me_state;
    logic [NUM_SRC-1:0] serviceable;
    logic [NUM_SRC-1:0] win_onehot;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic               dispatch;
    logic [NUM_SRC-1:0] flags_q;

    assign serviceable = r_q.en & r_q.flg;

    irq_prio_enc #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_enc (
        .cand_i   (serviceable),
        .any_o    (win_any),
        .idx_o    (win_idx),
        .onehot_o (win_onehot)
    );

    irq_vec_map #(
        .N      (NUM_SRC),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .BASE   (VEC_BASE),
        .STRIDE (VEC_STEP)
    ) u_vec (
        .idx_i (win_idx),
        .vec_o (vector_o)
    );

    assign dispatch = step_i && (me_state == ME_LIVE) && win_any;

    irq_me_fsm u_me (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (step_i),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .reti_i     (reti_i),
        .dispatch_i (dispatch),
        .state_o    (me_state)
    );

    always_comb begin
        r_d = r_q;
        if (reg_wr_i && !reg_sel_i) begin
            r_d.en = NUM_SRC'(reg_wdata_i);
        end
        if (reg_wr_i && reg_sel_i) begin
            r_d.flg = NUM_SRC'(reg_wdata_i);
        end
        if (dispatch) begin
            r_d.flg = r_d.flg & ~win_onehot;
        end
        // New requests win over the dispatch clear
        r_d.flg = r_d.flg | req_i;
        if (dispatch) begin
            r_d.push_pend = 1'b1;
            r_d.push_pc   = pc_i;
        end else if (push_done_i) begin
            r_d.push_pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flags_q      = r_q.flg;
    assign reg_rdata_o  = DATA_W'(reg_sel_i ? r_q.flg : r_q.en);
    assign disp_valid_o = dispatch;
    assign cost_o       = COST_W'(DISPATCH_CYCLES);
    assign me_state_o   = me_state;
    assign push_req_o   = r_q.push_pend;
    assign push_addr_o  = r_q.push_pc;

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int unsigned NUM_SRC  = 5,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned COST_W   = 4,
    parameter int unsigned VEC_BASE = 'h40,
    parameter int unsigned VEC_STEP = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] req_i,
    input logic               ei_i,
    input logic               di_i,
    input logic               reti_i,
    input logic               step_i,
    input logic               disp_valid_o,
    input logic [ADDR_W-1:0]  vector_o,
    input logic [COST_W-1:0]  cost_o,
    input logic [1:0]         me_state_o,
    input logic               push_req_o,
    input logic               push_done_i,
    input logic [NUM_SRC-1:0] flags_q
);

    localparam logic [ADDR_W-1:0] V_LO = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] V_HI = ADDR_W'(VEC_BASE + (NUM_SRC - 1) * VEC_STEP);

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (me_state_o == 2'd0 && flags_q == '0 && !push_req_o));

    assert_req_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |=> ((flags_q & $past(req_i)) == $past(req_i)));

    assert_ei_arms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ei_i && !di_i && !reti_i) |=> (me_state_o == 2'd1));

    assert_armed_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && me_state_o == 2'd1 && !ei_i && !di_i && !reti_i) |=> (me_state_o == 2'd2));

    assert_di_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        di_i |=> (me_state_o == 2'd0));

    assert_reti_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && !di_i) |=> (me_state_o == 2'd3));

    assert_disp_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_valid_o |-> (step_i && me_state_o == 2'd3 && flags_q != '0));

    assert_vec_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_valid_o |-> (vector_o >= V_LO && vector_o <= V_HI));

    assert_disp_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disp_valid_o && !ei_i && !di_i && !reti_i) |=> (me_state_o == 2'd0));

    assert_cost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_valid_o |-> (cost_o == COST_W'(5)));

    assert_push_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_valid_o |=> push_req_o);

    assert_push_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_req_o && !push_done_i) |=> push_req_o);

endmodule

bind irq_dispatch_ctrl irq_dispatch_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .COST_W   (COST_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .reti_i       (reti_i),
    .step_i       (step_i),
    .disp_valid_o (disp_valid_o),
    .vector_o     (vector_o),
    .cost_o       (cost_o),
    .me_state_o   (me_state_o),
    .push_req_o   (push_req_o),
    .push_done_i  (push_done_i),
    .flags_q      (flags_q)
);

// File: tb/irq_dispatch_ctrl_tb_top.sv
module irq_dispatch_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [4:0]  req_i = '0;
    logic        ei_i = 1'b0, di_i = 1'b0, reti_i = 1'b0, step_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic        disp_valid_o;
    logic [15:0] vector_o;
    logic [3:0]  cost_o;
    logic [1:0]  me_state_o;
    logic        push_req_o;
    logic [15:0] push_addr_o;
    logic        push_done_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    irq_dispatch_ctrl dut_i (
        .clk_i, .rst_ni, .req_i, .ei_i, .di_i, .reti_i, .step_i, .pc_i,
        .reg_wr_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
        .disp_valid_o, .vector_o, .cost_o, .me_state_o,
        .push_req_o, .push_addr_o, .push_done_i
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk_i);
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel_i = sel;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        cyc();
        reg_wr_i = 1'b0;
    endtask

    task automatic strobe(input bit e, input bit d, input bit r);
        ei_i = e; di_i = d; reti_i = r;
        cyc();
        ei_i = 1'b0; di_i = 1'b0; reti_i = 1'b0;
    endtask

    // Driver: one step, with the expected dispatch queued for the monitor
    task automatic do_step(input bit exp_disp, input logic [15:0] vec,
                           input logic [4:0] req, input string tag);
        step_i = 1'b1; req_i = req;
        if (exp_disp) exp_q.push_back(vec);
        cyc();
        step_i = 1'b0; req_i = '0;
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic chk_reg(input logic sel, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        rd(sel, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic chk_me(input logic [1:0] exp, input string tag);
        chk(me_state_o == exp, tag, me_state_o, exp);
    endtask

    // Monitor: samples a quarter period after the driving edge
    initial begin
        forever begin
            @(negedge clk_i);
            #(CLK_PERIOD/4);
            if (disp_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected dispatch", vector_o, 0);
                end else begin
                    logic [15:0] v;
                    v = exp_q.pop_front();
                    chk(vector_o == v, "R8 vector", vector_o, v);
                    chk(cost_o == 4'd5, "R9 cost", cost_o, 5);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cyc(); cyc();
        // R1 reset state
        chk_me(2'd0, "R1 state");
        chk_reg(1'b0, 8'h00, "R1 mask");
        chk_reg(1'b1, 8'h00, "R1 flags");
        chk(!push_req_o && !disp_valid_o, "R1 outputs", push_req_o, 0);
        rst_ni = 1'b1;
        cyc();

        // R2 register port
        wr(1'b0, 8'hFF);
        chk_reg(1'b0, 8'h1F, "R2 mask write");
        wr(1'b1, 8'hE0);
        chk_reg(1'b1, 8'h00, "R2 flags upper bits");

        // R3 request pulse
        req_i = 5'h04; cyc(); req_i = '0;
        chk_reg(1'b1, 8'h04, "R3 timer flag");

        // R7 no dispatch while off
        do_step(1'b0, 16'h0, 5'h0, "R7 off");

        // R4 delayed enable
        strobe(1'b1, 1'b0, 1'b0);
        chk_me(2'd1, "R4 armed");
        do_step(1'b0, 16'h0, 5'h0, "R4 armed step");
        chk_me(2'd2, "R4 primed");
        do_step(1'b0, 16'h0, 5'h0, "R4 primed step");
        chk_me(2'd3, "R4 live");

        // R9/R10 dispatch of timer
        pc_i = 16'h1234;
        do_step(1'b1, 16'h0050, 5'h0, "R8 timer dispatch");
        chk_me(2'd0, "R9 off after dispatch");
        chk_reg(1'b1, 8'h00, "R9 flag cleared");
        chk(push_req_o && push_addr_o == 16'h1234, "R10 push", push_addr_o, 16'h1234);
        cyc(); cyc();
        chk(push_req_o == 1'b1, "R10 push held", push_req_o, 1);
        push_done_i = 1'b1; cyc(); push_done_i = 1'b0;
        chk(push_req_o == 1'b0, "R10 push released", push_req_o, 0);

        // R8 priority with mixed set
        wr(1'b1, 8'h1A);
        strobe(1'b0, 1'b0, 1'b1);
        chk_me(2'd3, "R6 return live");
        do_step(1'b1, 16'h0048, 5'h0, "R8 bit1 wins");
        chk_reg(1'b1, 8'h18, "R9 only winner cleared");
        strobe(1'b0, 1'b0, 1'b1);
        do_step(1'b1, 16'h0058, 5'h0, "R8 bit3 wins");
        strobe(1'b0, 1'b0, 1'b1);
        do_step(1'b1, 16'h0060, 5'h0, "R8 bit4");
        chk_reg(1'b1, 8'h00, "R9 flags empty");
        wr(1'b1, 8'h1F);
        strobe(1'b0, 1'b0, 1'b1);
        do_step(1'b1, 16'h0040, 5'h0, "R8 bit0 wins");
        chk_reg(1'b1, 8'h1E, "R9 bit0 cleared");
        push_done_i = 1'b1; cyc(); push_done_i = 1'b0;

        // R7 masked sources
        wr(1'b0, 8'h04);
        wr(1'b1, 8'h1B);
        strobe(1'b0, 1'b0, 1'b1);
        do_step(1'b0, 16'h0, 5'h0, "R7 masked");
        chk_me(2'd3, "R7 stays live");

        // R5 disable cancels pending enable
        strobe(1'b0, 1'b1, 1'b0);
        chk_me(2'd0, "R5 off");
        strobe(1'b1, 1'b0, 1'b0);
        do_step(1'b0, 16'h0, 5'h0, "R5 armed step");
        strobe(1'b0, 1'b1, 1'b0);
        chk_me(2'd0, "R5 cancel primed");
        do_step(1'b0, 16'h0, 5'h0, "R5 step after cancel");
        do_step(1'b0, 16'h0, 5'h0, "R5 step after cancel 2");
        chk_me(2'd0, "R5 remains off");

        // R11 request and clear collide
        wr(1'b0, 8'h1F);
        wr(1'b1, 8'h02);
        strobe(1'b0, 1'b0, 1'b1);
        do_step(1'b1, 16'h0048, 5'h02, "R11 collide dispatch");
        chk_reg(1'b1, 8'h02, "R11 set wins");
        push_done_i = 1'b1; cyc(); push_done_i = 1'b0;

        // R12 strobe priority
        strobe(1'b1, 1'b1, 1'b0);
        chk_me(2'd0, "R12 disable over enable");
        strobe(1'b0, 1'b1, 1'b1);
        chk_me(2'd0, "R12 disable over return");
        strobe(1'b1, 1'b0, 1'b1);
        chk_me(2'd3, "R12 return over enable");
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        step_i = 1'b1; reti_i = 1'b1; cyc(); step_i = 1'b0; reti_i = 1'b0;
        chk_me(2'd3, "R12 strobe over step");

        cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule